// File: doc/BRIEF.md
# Prescaled Up-Counting Timer Base

This block is the time base of a general-purpose timer. A 16-bit counter counts up from zero to a programmable reload limit, paced by a clock enable that a prescaler derives from the system clock. When the counter passes the limit it wraps to zero. The wrap raises an update event and sets a sticky update flag, which software clears. Software can also force an update at any time, either by writing a one to an event register or through a single-cycle external trigger. A forced update clears both the prescaler and the main counter.

The prescaler division value is double-buffered. Software writes into a staging register, and that register can be read back at once. Its value moves into the working prescaler only on an update event, so a new rate always begins at a clean period boundary. The reload limit is written straight into its working register. A reload limit of zero freezes the counter. The counter readback word carries a read-only copy of the update flag in its most significant bit, so one read returns both the count and the flag.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the counter reads 0, the prescaler reads 0, the reload limit reads 0xFFFF, the update flag is 0 and counting is disabled.
- R2: Byte offsets: 0x00 control (bit 0 enables counting), 0x10 status (bit 0 is the update flag), 0x14 event (bit 0 forces an update), 0x24 counter (bits 15:0 read/write, bits 30:16 read as zero), 0x28 prescaler (bits 15:0), 0x2C reload limit (bits 15:0). Every other offset reads as zero.
- R3: While counting is enabled and the reload limit A is not zero, the counter advances once every P+1 clocks, where P is the working prescaler value. On a counter step taken with the count at or above A, the counter wraps to 0 and an update event occurs. Updates from wrapping therefore repeat every (P+1)*(A+1) clocks.
- R4: A prescaler write is visible on readback at once. It changes the counting rate only after the next update event.
- R5: Writing 1 to event bit 0 clears the prescaler counter and the main counter, and causes an update event in that cycle. The update event loads the staged prescaler value and sets the flag.
- R6: A high level on ext_trig for one clock has the same effect as R5.
- R7: While the reload limit is zero, the counter does not advance and no wrap update occurs.
- R8: While the enable bit is 0, the counter holds its value.
- R9: Writing 0 to status bit 0 clears the flag, and writing 1 leaves it unchanged. When an update event falls in the same cycle as a clear, the flag is set.
- R10: Counter readback bit 31 equals the update flag. Writes to counter bit 31 do not change the flag.
- R11: upd_evt is high during exactly the clock cycles whose closing edge performs an update event. A forced update takes priority over a counter write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_trig | input | 1 | Reset-mode trigger, one-cycle pulse |
| upd_evt | output | 1 | High in the cycle an update event takes effect |
| irq_flag | output | 1 | Sticky update interrupt flag |

## Verification
The assertions assume that ext_trig and bus_we are synchronous single-cycle pulses, and that the working prescaler changes only when an update event loads it. This is what the bounded prescaler count relies on. The stimulus drives every input at the falling edge and holds each write for exactly one cycle. It stops counting before it alters the count or the flag directly, so the only source of an update is the one a test intends. Period checks always begin at an update pulse or a forced update, so the prescaler phase is known.

// File: rtl/tmrb_pkg.sv
package tmrb_pkg;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EVT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_PSC  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_ARR  = 8'h2C;

    localparam logic [CNT_W-1:0] ARR_RST = {CNT_W{1'b1}};

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_EVT,
        SEL_CNT,
        SEL_PSC,
        SEL_ARR
    } sel_e;

    // pulses the register block hands to the datapath
    typedef struct packed {
        logic force_upd;   // software update request
        logic flag_clr;    // status write of 0
        logic cnt_wr;      // direct counter write
    } strobe_t;

    function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
        sel_e s;
        case (a)
            OFS_CTRL: s = SEL_CTRL;
            OFS_STAT: s = SEL_STAT;
            OFS_EVT:  s = SEL_EVT;
            OFS_CNT:  s = SEL_CNT;
            OFS_PSC:  s = SEL_PSC;
            OFS_ARR:  s = SEL_ARR;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmrb_regs.sv
module tmrb_regs
    import tmrb_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic [W-1:0]  cnt_val,
    input  logic          flag,
    output logic [DW-1:0] rdata,
    output logic          en,
    output logic [W-1:0]  psc_pre,
    output logic [W-1:0]  arr,
    output strobe_t       stb,
    output logic [W-1:0]  cnt_wdata
);
    localparam int PAD_W = DW - 1 - W;

    sel_e sel;
    assign sel = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= 1'b0;
            psc_pre <= '0;
            arr     <= ARR_RST;
        end else if (we) begin
            case (sel)
                SEL_CTRL: en      <= wdata[0];
                SEL_PSC:  psc_pre <= wdata[W-1:0];
                SEL_ARR:  arr     <= wdata[W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        stb.force_upd = we && (sel == SEL_EVT) && wdata[0];
        stb.flag_clr  = we && (sel == SEL_STAT) && !wdata[0];
        stb.cnt_wr    = we && (sel == SEL_CNT);
    end
    assign cnt_wdata = wdata[W-1:0];

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: rdata[0] = en;
            SEL_STAT: rdata[0] = flag;
            SEL_CNT:  rdata = {flag, {PAD_W{1'b0}}, cnt_val};
            SEL_PSC:  rdata[W-1:0] = psc_pre;
            SEL_ARR:  rdata[W-1:0] = arr;
            default:  rdata = '0;
        endcase
    end

    // R4: staged prescaler moves only under a PSC write
    p_psc_stage_r4: assert property (@(posedge clk) disable iff (rst)
        !(we && sel == SEL_PSC) |=> $stable(psc_pre));

endmodule

// File: rtl/tmrb_presc.sv
module tmrb_presc
    import tmrb_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         force_upd,
    input  logic         upd,
    input  logic [W-1:0] psc_pre,
    output logic         tick
);
    logic [W-1:0] psc_act;
    logic [W-1:0] pcnt;

    assign tick = run && (pcnt == psc_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt    <= '0;
            psc_act <= '0;
        end else begin
            if (upd)
                psc_act <= psc_pre;
            if (force_upd || tick)
                pcnt <= '0;
            else if (run)
                pcnt <= pcnt + 1'b1;
        end
    end

    // R3: prescaler phase never passes the working divide value
    p_pcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        pcnt <= psc_act);

    // R4: working divide value changes only on update events
    p_psc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(psc_act));

    // R5: forced update restarts the prescaler
    p_pcnt_clear_r5: assert property (@(posedge clk) disable iff (rst)
        force_upd |=> (pcnt == '0));

endmodule

// File: rtl/tmrb_count.sv
module tmrb_count
    import tmrb_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         force_upd,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] arr,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic at_top;

    assign at_top = (cnt >= arr);
    assign wrap   = tick && !force_upd && !wr && at_top;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (force_upd)
            cnt <= '0;
        else if (wr)
            cnt <= wdata;
        else if (tick)
            cnt <= at_top ? '0 : cnt + 1'b1;
    end

    // R8: without a step, clear or write the count holds
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!tick && !force_upd && !wr) |=> $stable(cnt));

    // R11: forced clear beats a same-cycle write
    p_force_wins_r11: assert property (@(posedge clk) disable iff (rst)
        force_upd |=> (cnt == '0));

    // R3: a wrap lands on zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

endmodule

// File: rtl/tmrb_flag.sv
module tmrb_flag (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (upd)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R9: set from an update wins over a same-cycle clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        upd |=> flag);

    // R9: flag only falls on a clear request
    p_fall_cause_r9: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
    import tmrb_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ext_trig,
    output logic          upd_evt,
    output logic          irq_flag
);
    logic         en;
    logic [W-1:0] psc_pre;
    logic [W-1:0] arr;
    strobe_t      stb;
    logic [W-1:0] cnt_wdata;
    logic [W-1:0] cnt_q;
    logic         flag_q;
    logic         run;
    logic         tick;
    logic         wrap;
    logic         force_upd;

    assign run       = en && (arr != '0);
    assign force_upd = stb.force_upd || ext_trig;
    assign upd_evt   = force_upd || wrap;
    assign irq_flag  = flag_q;

    tmrb_regs #(.W(W), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .cnt_val   (cnt_q),
        .flag      (flag_q),
        .rdata     (bus_rdata),
        .en        (en),
        .psc_pre   (psc_pre),
        .arr       (arr),
        .stb       (stb),
        .cnt_wdata (cnt_wdata)
    );

    tmrb_presc #(.W(W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .force_upd (force_upd),
        .upd       (upd_evt),
        .psc_pre   (psc_pre),
        .tick      (tick)
    );

    tmrb_count #(.W(W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .force_upd (force_upd),
        .wr        (stb.cnt_wr),
        .wdata     (cnt_wdata),
        .arr       (arr),
        .cnt       (cnt_q),
        .wrap      (wrap)
    );

    tmrb_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .upd  (upd_evt),
        .clr  (stb.flag_clr),
        .flag (flag_q)
    );

    // R7: a zero reload limit blocks every counter step
    p_zero_arr_r7: assert property (@(posedge clk) disable iff (rst)
        (arr == '0) |-> !tick);

    // R8: no step while disabled
    p_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tick);

    // R6: an external trigger produces an update and a clear
    p_trig_r6: assert property (@(posedge clk) disable iff (rst)
        ext_trig |-> upd_evt);

    // R10: counter readback top bit follows the flag
    p_mirror_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_CNT) |-> (bus_rdata[DW-1] == flag_q));

endmodule

// File: tb/sim_tmr_timebase.sv
module sim_tmr_timebase;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_trig = 1'b0;
    logic        upd_evt;
    logic        irq_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    tmr_timebase u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
        .upd_evt(upd_evt), .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // reads take no clock time: read port is combinational
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // write held for one cycle; returns at the falling edge after commit
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // number of falling edges until upd_evt is seen high
    task automatic wait_evt(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!upd_evt && n < 5000);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h24, d); chk("R1 counter", d, 32'h0);
        rd(8'h28, d); chk("R1 prescaler", d, 32'h0);
        rd(8'h2C, d); chk("R1 reload", d, 32'h0000_FFFF);
        rd(8'h10, d); chk("R1 flag", d, 32'h0);
        rd(8'h00, d); chk("R1 enable", d, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        rd(8'h20, d); chk("R2 unused offset", d, 32'h0);
        wr(8'h24, 32'hFFFF_1234);
        rd(8'h24, d); chk("R10 bit31 write ignored, R2 field", d, 32'h0000_1234);
        chk("R10 flag untouched", {31'b0, irq_flag}, 32'h0);
        wr(8'h24, 32'h0);
    endtask

    task automatic t_rate();
        logic [31:0] d;
        int n;
        wr(8'h2C, 32'h4);
        wr(8'h00, 32'h1);
        wait_evt(n);
        wait_evt(n); chk("R3 period P=0 A=4", n, 32'd5);
        rd(8'h10, d); chk("R3 flag set on wrap", d, 32'h1);
        rd(8'h24, d); chk("R10 mirror high", {d[31], 31'b0}, 32'h8000_0000);
        wr(8'h28, 32'h2);
        rd(8'h28, d); chk("R4 staged readback", d, 32'h2);
        wait_evt(n); chk("R4 old rate until update", {31'b0, (n <= 5)}, 32'h1);
        wait_evt(n); chk("R4 new period P=2 A=4", n, 32'd15);
        wait_evt(n); chk("R11 pulse spacing", n, 32'd15);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(8'h00, 32'h0);
        wr(8'h10, 32'h1);
        rd(8'h10, d); chk("R9 write 1 no effect", d, 32'h1);
        wr(8'h10, 32'h0);
        rd(8'h10, d); chk("R9 write 0 clears", d, 32'h0);
        rd(8'h24, d); chk("R10 mirror low", {d[31], 31'b0}, 32'h0);
        wr(8'h24, 32'h8000_0003);
        rd(8'h10, d); chk("R10 write bit31 keeps flag", d, 32'h0);
    endtask

    task automatic t_ug();
        logic [31:0] d;
        int n;
        wr(8'h2C, 32'h2);
        wr(8'h28, 32'h1);
        wr(8'h00, 32'h1);
        @(negedge clk);
        bus_addr = 8'h14; bus_wdata = 32'h1; bus_we = 1'b1;
        #1 chk("R11 pulse in force cycle", {31'b0, upd_evt}, 32'h1);
        @(negedge clk);
        bus_we = 1'b0;
        rd(8'h24, d); chk("R5 cleared and flagged", d, 32'h8000_0000);
        // counted from the edge after the force: (P+1)*(A+1)-1 = 5
        wait_evt(n); chk("R5 staged P loaded", n, 32'd5);
    endtask

    task automatic t_trig();
        logic [31:0] d;
        wr(8'h00, 32'h0);
        wr(8'h10, 32'h0);
        wr(8'h24, 32'h7);
        @(negedge clk);
        ext_trig = 1'b1;
        bus_addr = 8'h10; bus_wdata = 32'h0; bus_we = 1'b1;
        #1 chk("R11 trigger pulse", {31'b0, upd_evt}, 32'h1);
        @(negedge clk);
        ext_trig = 1'b0; bus_we = 1'b0;
        rd(8'h10, d); chk("R9 set wins over clear", d, 32'h1);
        rd(8'h24, d); chk("R6 trigger clears counter", d[15:0], 32'h0);
        // force beats counter write in same cycle
        @(negedge clk);
        ext_trig = 1'b1;
        bus_addr = 8'h24; bus_wdata = 32'h55; bus_we = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0; bus_we = 1'b0;
        rd(8'h24, d); chk("R11 force over write", d[15:0], 32'h0);
    endtask

    task automatic t_halt();
        logic [31:0] d;
        int seen;
        wr(8'h24, 32'h3);
        wr(8'h2C, 32'h0);
        wr(8'h00, 32'h1);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (upd_evt) seen++;
        end
        chk("R7 no update at zero limit", seen, 32'd0);
        rd(8'h24, d); chk("R7 count frozen", d[15:0], 32'h3);
        wr(8'h00, 32'h0);
        wr(8'h2C, 32'h5);
        wr(8'h24, 32'h2);
        repeat (20) @(negedge clk);
        rd(8'h24, d); chk("R8 disabled holds", d[15:0], 32'h2);
    endtask

    task automatic t_above();
        int n;
        wr(8'h24, 32'h9);
        wr(8'h00, 32'h1);
        // P=1: first step within 2 clocks wraps since 9 >= 5
        wait_evt(n); chk("R3 wrap from above limit", {31'b0, (n <= 2)}, 32'h1);
        wait_evt(n); chk("R3 period P=1 A=5", n, 32'd12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_rate();
        t_clear();
        t_ug();
        t_trig();
        t_halt();
        t_above();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule